// File: doc/BRIEF.md
# Read-to-take hardware semaphore bank

This block holds three one-bit hardware locks shared by a host processor and an internal link-layer engine. A lock reads as 1 when free and 0 when held. The host claims a lock with a single register read: the read returns the lock's value and clears it in the same operation, so a returned 1 means the host now owns it and a returned 0 means another party already had it. The host gives a lock back by writing the value 1 to its register.

The engine reaches locks 0 and 1 through per-lock take and release strobes and through a small task sequencer. The sequencer claims lock 0 when a task starts, claims lock 1 when radio setup is reported done, and frees both when the task ends. Lock 2 belongs to the host alone. Any engine claim that finds its lock held raises a sticky error flag, which the host reads and clears through a fourth register.

Top module: `semaphoreBank`

## Requirements
- R1: After reset all three locks are free, errFlag is 0 and taskActive is 0.
- R2: A host read of address 0, 1 or 2 loads the lock's value into hostRdata bit 0 (bits 7..1 zero) on the clock edge that samples hostRd, and leaves that lock held (0).
- R3: A host read that finds a lock held returns 0 and changes nothing; every later read of that lock returns 0 until it is freed.
- R4: A host write of the exact value 8'h01 to address 0, 1 or 2 frees that lock; a write of any other value has no effect.
- R5: taskStart while taskActive is 0 and lock 0 is free claims lock 0 and sets taskActive on the next edge.
- R6: setupDone while a task is active and lock 1 is not yet claimed by the sequencer claims lock 1.
- R7: taskEnd during an active task frees the locks the sequencer claimed for it and clears taskActive.
- R8: The engine never claims or frees lock 2; it changes only through host reads and writes.
- R9: An engine claim (sequencer or engTake) of a held lock sets errFlag; a failed task start leaves taskActive at 0, and a failed setup claim frees lock 0 and ends the task.
- R10: When a host read and an engine claim hit the same free lock in one cycle, the engine wins and the host read returns 0.
- R11: errFlag stays set until the host writes 8'h01 to address 3; a read of address 3 returns errFlag in bit 0; a new failure in the same cycle as the clear leaves errFlag set.
- R12: engTake[i] claims lock i (i = 0 or 1) when free, and engRelease[i] frees it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostAddr | input | 2 | Host register select: 0..2 locks, 3 error register |
| hostRd | input | 1 | Host read strobe (claims the addressed lock) |
| hostWr | input | 1 | Host write strobe |
| hostWdata | input | 8 | Host write value; only 8'h01 acts |
| hostRdata | output | 8 | Registered read value, held until the next read |
| taskStart | input | 1 | Engine task begins |
| setupDone | input | 1 | Engine radio setup finished |
| taskEnd | input | 1 | Engine task finished |
| engTake | input | 2 | Engine claim strobes for locks 0 and 1 |
| engRelease | input | 2 | Engine free strobes for locks 0 and 1 |
| errFlag | output | 1 | Sticky failed-claim indication |
| taskActive | output | 1 | Sequencer is inside a task |

## Verification
Every result here is due exactly one clock edge after its stimulus: hostRdata, the lock bits, errFlag and taskActive are all registers loaded from that cycle's strobes. The bench drives strobes just after a falling edge and reads outputs at the next falling edge, half a period after the edge that loads them. A behavioural model updated on the same rising edge is compared on every cycle, and directed checks target the same-cycle collisions: read against engine claim, and error set against error clear.

// File: rtl/semPkg.sv
package semPkg;
  localparam int unsigned SEM_COUNT = 3;
  localparam int unsigned ENG_COUNT = 2;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_RUN
  } phaseT;

  typedef struct packed {
    logic [SEM_COUNT-1:0] takeOk;
    logic [SEM_COUNT-1:0] claim;
    logic [SEM_COUNT-1:0] free;
    logic                 errSet;
    logic                 errClr;
    logic                 rdLoad;
  } semStrobeT;
endpackage

// File: rtl/semCtrl.sv
module semCtrl
  import semPkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic                 hostRd,
  input  logic                 hostWr,
  input  logic [DATA_W-1:0]    hostWdata,
  input  logic                 taskStart,
  input  logic                 setupDone,
  input  logic                 taskEnd,
  input  logic [ENG_COUNT-1:0] engTake,
  input  logic [ENG_COUNT-1:0] engRelease,
  input  logic [SEM_COUNT-1:0] semNow,
  output semStrobeT            strobe,
  output logic                 taskActive
);
  localparam logic [ADDR_W-1:0] ERR_ADDR = ADDR_W'(SEM_COUNT);

  phaseT phase, phaseNxt;
  logic [SEM_COUNT-1:0] seqTake, seqFree, takeReq, hostHit;
  logic [SEM_COUNT-1:0] engTakeW, engRelW;
  logic writeOne;

  assign engTakeW = SEM_COUNT'(engTake);
  assign engRelW  = SEM_COUNT'(engRelease);
  assign writeOne = hostWr && (hostWdata == DATA_W'(1));

  // task sequencer: claims lock 0 at start, lock 1 after setup
  always_comb begin
    phaseNxt = phase;
    seqTake  = '0;
    seqFree  = '0;
    unique case (phase)
      PH_IDLE: begin
        if (taskStart) begin
          seqTake[0] = 1'b1;
          if (semNow[0]) phaseNxt = PH_SETUP;
        end
      end
      PH_SETUP: begin
        if (taskEnd) begin
          seqFree[0] = 1'b1;
          phaseNxt   = PH_IDLE;
        end else if (setupDone) begin
          seqTake[1] = 1'b1;
          if (semNow[1]) begin
            phaseNxt = PH_RUN;
          end else begin
            seqFree[0] = 1'b1;
            phaseNxt   = PH_IDLE;
          end
        end
      end
      PH_RUN: begin
        if (taskEnd) begin
          seqFree[0] = 1'b1;
          seqFree[1] = 1'b1;
          phaseNxt   = PH_IDLE;
        end
      end
      default: phaseNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNxt;
  end

  assign taskActive = (phase != PH_IDLE);

  always_comb begin
    for (int i = 0; i < SEM_COUNT; i++) begin
      hostHit[i] = (hostAddr == ADDR_W'(i));
    end
  end

  assign takeReq = engTakeW | seqTake;

  always_comb begin
    strobe.takeOk = takeReq & semNow;
    strobe.errSet = |(takeReq & ~semNow);
    strobe.claim  = hostRd ? hostHit : '0;
    strobe.free   = engRelW | seqFree | (writeOne ? hostHit : '0);
    strobe.errClr = writeOne && (hostAddr == ERR_ADDR);
    strobe.rdLoad = hostRd;
  end
endmodule

// File: rtl/semDatapath.sv
module semDatapath
  import semPkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  semStrobeT            strobe,
  input  logic [ADDR_W-1:0]    hostAddr,
  output logic [SEM_COUNT-1:0] semNow,
  output logic                 errFlag,
  output logic [DATA_W-1:0]    hostRdata
);
  localparam logic [ADDR_W-1:0] ERR_ADDR = ADDR_W'(SEM_COUNT);

  logic [SEM_COUNT-1:0] semNxt;
  logic rdBit;

  // clears first, then frees: a release in the same cycle wins
  assign semNxt = (semNow & ~(strobe.takeOk | strobe.claim)) | strobe.free;

  always_comb begin
    rdBit = 1'b0;
    for (int i = 0; i < SEM_COUNT; i++) begin
      if (hostAddr == ADDR_W'(i)) rdBit = semNow[i] & ~strobe.takeOk[i];
    end
    if (hostAddr == ERR_ADDR) rdBit = errFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      semNow    <= '1;
      errFlag   <= 1'b0;
      hostRdata <= '0;
    end else begin
      semNow  <= semNxt;
      errFlag <= (errFlag & ~strobe.errClr) | strobe.errSet;
      if (strobe.rdLoad) hostRdata <= DATA_W'(rdBit);
    end
  end
endmodule

// File: rtl/semaphoreBank.sv
module semaphoreBank
  import semPkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic                 hostRd,
  input  logic                 hostWr,
  input  logic [DATA_W-1:0]    hostWdata,
  output logic [DATA_W-1:0]    hostRdata,
  input  logic                 taskStart,
  input  logic                 setupDone,
  input  logic                 taskEnd,
  input  logic [ENG_COUNT-1:0] engTake,
  input  logic [ENG_COUNT-1:0] engRelease,
  output logic                 errFlag,
  output logic                 taskActive
);
  semStrobeT strobe;
  logic [SEM_COUNT-1:0] semNow;

  semCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostRd(hostRd),
    .hostWr(hostWr), .hostWdata(hostWdata), .taskStart(taskStart),
    .setupDone(setupDone), .taskEnd(taskEnd), .engTake(engTake),
    .engRelease(engRelease), .semNow(semNow), .strobe(strobe),
    .taskActive(taskActive)
  );

  semDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostAddr(hostAddr),
    .semNow(semNow), .errFlag(errFlag), .hostRdata(hostRdata)
  );
endmodule

// File: rtl/semaphoreBankChecker.sv
module semaphoreBankChecker
  import semPkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    hostAddr,
  input logic                 hostRd,
  input logic                 hostWr,
  input logic [DATA_W-1:0]    hostWdata,
  input logic [DATA_W-1:0]    hostRdata,
  input logic                 taskStart,
  input logic                 setupDone,
  input logic                 taskEnd,
  input logic [ENG_COUNT-1:0] engTake,
  input logic [ENG_COUNT-1:0] engRelease,
  input logic                 errFlag,
  input logic                 taskActive,
  input logic [SEM_COUNT-1:0] semNow
);
  localparam logic [ADDR_W-1:0] ERR_ADDR = ADDR_W'(SEM_COUNT);
  logic [SEM_COUNT-1:0] engRelW;
  logic engQuiet;
  assign engRelW  = SEM_COUNT'(engRelease);
  assign engQuiet = !taskStart && !setupDone && !taskEnd && (engTake == '0) && (engRelease == '0);

  for (genvar g = 0; g < SEM_COUNT; g++) begin : gLock
    a_r2_read_claims: assert property (@(posedge clk) disable iff (!rstN)
      hostRd && !hostWr && hostAddr == ADDR_W'(g) && !engRelW[g] && !taskEnd && !setupDone
      |=> !semNow[g]);
    a_r3_held_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
      hostRd && hostAddr == ADDR_W'(g) && !semNow[g] |=> hostRdata == '0);
    a_r4_write_one_frees: assert property (@(posedge clk) disable iff (!rstN)
      hostWr && hostAddr == ADDR_W'(g) && hostWdata == DATA_W'(1) |=> semNow[g]);
    a_r4_other_write_nop: assert property (@(posedge clk) disable iff (!rstN)
      hostWr && !hostRd && hostAddr == ADDR_W'(g) && hostWdata != DATA_W'(1) && engQuiet
      |=> semNow[g] == $past(semNow[g]));
  end

  a_r8_last_lock_host_only: assert property (@(posedge clk) disable iff (!rstN)
    !hostRd && !hostWr |=> $stable(semNow[SEM_COUNT-1]));
  a_r9_busy_start_errors: assert property (@(posedge clk) disable iff (!rstN)
    taskStart && !taskActive && !semNow[0] |=> errFlag && !taskActive);
  a_r10_engine_wins: assert property (@(posedge clk) disable iff (!rstN)
    hostRd && hostAddr == '0 && taskStart && !taskActive && semNow[0]
    |=> hostRdata == '0 && taskActive);
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !(hostWr && hostAddr == ERR_ADDR && hostWdata == DATA_W'(1)) |=> errFlag);
endmodule

bind semaphoreBank semaphoreBankChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
  .hostWdata(hostWdata), .hostRdata(hostRdata), .taskStart(taskStart),
  .setupDone(setupDone), .taskEnd(taskEnd), .engTake(engTake),
  .engRelease(engRelease), .errFlag(errFlag), .taskActive(taskActive),
  .semNow(semNow)
);

// File: tb/semaphoreBank_test.sv
module semaphoreBank_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] hostAddr = '0;
  logic       hostRd = 1'b0, hostWr = 1'b0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic       taskStart = 1'b0, setupDone = 1'b0, taskEnd = 1'b0;
  logic [1:0] engTake = '0, engRelease = '0;
  logic       errFlag, taskActive;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  semaphoreBank uut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .taskStart(taskStart),
    .setupDone(setupDone), .taskEnd(taskEnd), .engTake(engTake),
    .engRelease(engRelease), .errFlag(errFlag), .taskActive(taskActive)
  );

  // behavioural reference model
  logic [2:0] mSem, tk, rel;
  logic mErr, mRd, fail;
  int mPhase, nPhase;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSem = 3'b111; mErr = 1'b0; mRd = 1'b0; mPhase = 0;
    end else begin
      tk = {1'b0, engTake};
      rel = {1'b0, engRelease};
      nPhase = mPhase;
      if (mPhase == 0 && taskStart) begin
        tk[0] = 1'b1;
        nPhase = mSem[0] ? 1 : 0;
      end else if (mPhase == 1) begin
        if (taskEnd) begin rel[0] = 1'b1; nPhase = 0; end
        else if (setupDone) begin
          tk[1] = 1'b1;
          if (mSem[1]) nPhase = 2;
          else begin rel[0] = 1'b1; nPhase = 0; end
        end
      end else if (mPhase == 2 && taskEnd) begin
        rel[0] = 1'b1; rel[1] = 1'b1; nPhase = 0;
      end
      if (hostWr && hostAddr < 3 && hostWdata == 8'h01) rel[hostAddr] = 1'b1;
      fail = |(tk & ~mSem);
      if (hostRd) mRd = (hostAddr == 3) ? mErr : (mSem[hostAddr] & ~tk[hostAddr]);
      mSem = mSem & ~tk;
      if (hostRd && hostAddr < 3) mSem[hostAddr] = 1'b0;
      mSem = mSem | rel;
      mErr = (mErr && !(hostWr && hostAddr == 3 && hostWdata == 8'h01)) || fail;
      mPhase = nPhase;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle model comparison, half a period after the loading edge
  always @(negedge clk) begin
    if (rstN) begin
      chk("R2 R3 R10 model hostRdata", hostRdata, {7'b0, mRd});
      chk("R9 R11 model errFlag", {7'b0, errFlag}, {7'b0, mErr});
      chk("R5 R7 model taskActive", {7'b0, taskActive}, {7'b0, 1'(mPhase != 0)});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic readReg(logic [1:0] a, logic [7:0] exp, string tag);
    hostRd = 1'b1; hostAddr = a;
    @(negedge clk);
    hostRd = 1'b0;
    chk(tag, hostRdata, exp);
  endtask

  task automatic writeReg(logic [1:0] a, logic [7:0] d);
    hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWr = 1'b0; hostWdata = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 errFlag after reset", {7'b0, errFlag}, 8'h00);
    chk("R1 taskActive after reset", {7'b0, taskActive}, 8'h00);
    readReg(0, 8'h01, "R1 R2 lock0 free after reset");
    readReg(1, 8'h01, "R1 R2 lock1 free after reset");
    readReg(2, 8'h01, "R1 R2 lock2 free after reset");
    readReg(2, 8'h00, "R3 lock2 held reads 0");
    readReg(2, 8'h00, "R3 lock2 still 0");
    writeReg(2, 8'h00);
    readReg(2, 8'h00, "R4 write 0 ignored");
    writeReg(2, 8'h03);
    readReg(2, 8'h00, "R4 write 3 ignored");
    writeReg(2, 8'h01);
    writeReg(1, 8'h01);
    readReg(2, 8'h01, "R4 write 1 frees lock2");
    writeReg(2, 8'h01);

    // host holds lock0, engine starts a task: error
    taskStart = 1'b1; @(negedge clk); taskStart = 1'b0;
    chk("R9 start with held lock0 errFlag", {7'b0, errFlag}, 8'h01);
    chk("R9 failed start taskActive", {7'b0, taskActive}, 8'h00);
    readReg(3, 8'h01, "R11 error register reads 1");
    repeat (2) @(negedge clk);
    chk("R11 errFlag sticky", {7'b0, errFlag}, 8'h01);
    writeReg(3, 8'h01);
    chk("R11 errFlag cleared", {7'b0, errFlag}, 8'h00);
    writeReg(0, 8'h01);

    // normal task
    taskStart = 1'b1; @(negedge clk); taskStart = 1'b0;
    chk("R5 task started", {7'b0, taskActive}, 8'h01);
    readReg(0, 8'h00, "R5 lock0 held by engine");
    setupDone = 1'b1; @(negedge clk); setupDone = 1'b0;
    readReg(1, 8'h00, "R6 lock1 held by engine");
    readReg(2, 8'h01, "R8 lock2 untouched by task");
    writeReg(2, 8'h01);
    taskEnd = 1'b1; @(negedge clk); taskEnd = 1'b0;
    chk("R7 task ended", {7'b0, taskActive}, 8'h00);
    chk("R7 no error in clean task", {7'b0, errFlag}, 8'h00);
    readReg(0, 8'h01, "R7 lock0 freed at end");
    readReg(1, 8'h01, "R7 lock1 freed at end");
    // host now holds lock1; setup claim fails
    writeReg(0, 8'h01);
    taskStart = 1'b1; @(negedge clk); taskStart = 1'b0;
    setupDone = 1'b1; @(negedge clk); setupDone = 1'b0;
    chk("R9 failed setup errFlag", {7'b0, errFlag}, 8'h01);
    chk("R9 failed setup ends task", {7'b0, taskActive}, 8'h00);
    readReg(0, 8'h01, "R9 failed setup frees lock0");
    writeReg(0, 8'h01);
    writeReg(1, 8'h01);
    writeReg(3, 8'h01);

    // same-cycle host read and engine claim
    hostRd = 1'b1; hostAddr = 2'd0; taskStart = 1'b1;
    @(negedge clk);
    hostRd = 1'b0; taskStart = 1'b0;
    chk("R10 engine wins, host reads 0", hostRdata, 8'h00);
    chk("R10 engine task active", {7'b0, taskActive}, 8'h01);
    chk("R10 no error on win", {7'b0, errFlag}, 8'h00);
    taskEnd = 1'b1; @(negedge clk); taskEnd = 1'b0;

    // manual strobes
    engTake = 2'b10; @(negedge clk); engTake = 2'b00;
    readReg(1, 8'h00, "R12 engTake claims lock1");
    engTake = 2'b10; @(negedge clk); engTake = 2'b00;
    chk("R9 R12 second engTake errors", {7'b0, errFlag}, 8'h01);
    engRelease = 2'b10; @(negedge clk); engRelease = 2'b00;
    readReg(1, 8'h01, "R12 engRelease frees lock1");
    writeReg(1, 8'h01);
    writeReg(3, 8'h01);

    // error clear collides with a new failure
    readReg(0, 8'h01, "R2 host claims lock0");
    hostWr = 1'b1; hostAddr = 2'd3; hostWdata = 8'h01; taskStart = 1'b1;
    @(negedge clk);
    hostWr = 1'b0; hostWdata = '0; taskStart = 1'b0;
    chk("R11 set beats clear", {7'b0, errFlag}, 8'h01);
    writeReg(3, 8'h01);
    chk("R11 later clear works", {7'b0, errFlag}, 8'h00);
    writeReg(0, 8'h01);
    repeat (2) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule